// File: doc/BRIEF.md
# Multiplexed Bus Write Sequencer

This block is a bus master for write traffic on a shared 32-bit address/data bus. A 5-bit command bus travels with it. The block takes one write request: a start address, a byte count from 1 up to `4*MAX_WORDS`, and a packed payload of 32-bit words. It turns that request into a run of bus cycles. Each run opens with an address cycle. The block repeats the address cycle until the external agent accepts it, and the cycle in which the agent accepts is the issue cycle. Data cycles then follow, either back to back or with one idle cycle between them.

A byte count of 5 to 7 does not fit a single word and is too short for a block transfer. The block sends it as two complete transactions. The first carries 4 bytes at the start address. The second carries the remaining 1 to 3 bytes at the start address plus 4.

The agent can cancel a transaction that is in its data phase. When it does, the block goes back to the address cycle of that same transaction. While the block works it raises a busy flag, and it ignores any new request until it is idle again.

Top module: `wseq_bus_writer`

## Requirements
- R1: After reset the block is idle: `busy`, `bus_valid`, `bus_cmd` and `bus_ad` are all zero.
- R2: An address cycle has `bus_cmd[4]`=0, `bus_cmd[3]`=1 only for a block transfer, and `bus_cmd[2:0]` set to the byte count minus 1 (single transfer) or the data-cycle count minus 1 (block). `bus_ad` carries the transaction address. The cycle repeats unchanged while `bus_accept` is low.
- R3: A data cycle has `bus_cmd[4]`=1, `bus_cmd[3]`=1 only on the final data cycle of the transaction, and `bus_cmd[2:0]` set to the data-cycle index counted from 0. `bus_ad` carries the payload word for that cycle, where word k is `req_data[32k+31:32k]`.
- R4: The first data cycle of a transaction occurs in the clock right after the issue cycle, which is the address cycle with `bus_accept` high.
- R5: A count of 1 to 4 bytes produces one transaction with exactly one data cycle, carrying word 0.
- R6: A count of 5, 6 or 7 bytes produces two transactions. The first has address A, a 4-byte size code and word 0. The second has address A+4, a size code of count minus 5, and word 1.
- R7: A count of 8 or more bytes produces one transaction of ceil(count/4) data cycles, which carry words 0 upward. Only the final one is tagged last, and after it the block returns to idle.
- R8: With `req_half_rate`=0, data cycles are back to back. With it set to 1 (sampled with the request), exactly one cycle with `bus_valid`=0 separates consecutive data cycles.
- R9: `bus_retry` high during a data cycle, or during the idle cycle between two data cycles, sends the block back to the address cycle of the current transaction. Data then restarts from that transaction's first word.
- R10: `busy` is high from the clock after a request is taken until the block returns to idle. A request presented while busy has no effect.
- R11: `bus_valid` is high on every address cycle and every data cycle, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present (taken only when idle) |
| req_addr | input | 32 | Start address |
| req_bytes | input | BYTES_W (6) | Byte count, 1 to 4*MAX_WORDS |
| req_data | input | 32*MAX_WORDS (256) | Payload, word k in bits 32k+31:32k |
| req_half_rate | input | 1 | 1: one data cycle every other clock |
| busy | output | 1 | Sequencer is working on a request |
| bus_ad | output | 32 | Multiplexed address/data bus |
| bus_cmd | output | 5 | Command: bit 4 data/address, bits 3:0 code |
| bus_valid | output | 1 | Address or data cycle present |
| bus_accept | input | 1 | Agent takes the address cycle |
| bus_retry | input | 1 | Agent cancels the transaction in its data phase |

## Verification
The bench builds the block with its default `MAX_WORDS` of 8. At that setting a block transfer reaches 8 data cycles, so the beat index uses all three low command bits, and a retry on beat 7 exercises the widest restart. Counts of 30 and 32 bytes cover both a partial final word and a full final word. The 1 to 7 byte cases reach every single-transfer size code and every split remainder. Both data rates are driven, with address acceptance delayed by several cycles.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
    localparam int unsigned AD_W  = 32;
    localparam int unsigned CMD_W = 5;
    localparam int unsigned IDX_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_GAP  = 2'd3
    } wseq_state_e;
endpackage

// File: rtl/wseq_split.sv
module wseq_split
    import wseq_pkg::*;
#(
    parameter int unsigned BYTES_W = 6,
    parameter int unsigned BEAT_W  = 3
) (
    input  logic [BYTES_W-1:0] total_bytes,
    input  logic               part,
    output logic               two_part,
    output logic               is_block,
    output logic [BEAT_W-1:0]  last_beat,
    output logic [IDX_W-1:0]   size_code
);
    logic [BYTES_W:0]   sum_d;
    logic [BYTES_W:0]   beats_m1_d;
    logic [BYTES_W-1:0] part_bytes_d;

    always_comb begin
        two_part     = (total_bytes >= BYTES_W'(5)) && (total_bytes <= BYTES_W'(7));
        is_block     = (total_bytes >= BYTES_W'(8));
        sum_d        = {1'b0, total_bytes} + (BYTES_W+1)'(3);
        beats_m1_d   = (sum_d >> 2) - (BYTES_W+1)'(1);
        last_beat    = is_block ? BEAT_W'(beats_m1_d) : '0;
        if (two_part) begin
            part_bytes_d = part ? (total_bytes - BYTES_W'(4)) : BYTES_W'(4);
        end else begin
            part_bytes_d = total_bytes;
        end
        size_code = is_block ? IDX_W'(beats_m1_d) : IDX_W'(part_bytes_d - BYTES_W'(1));
    end
endmodule

// File: rtl/wseq_wordsel.sv
module wseq_wordsel #(
    parameter int unsigned MAX_WORDS = 8,
    parameter int unsigned BEAT_W    = 3
) (
    input  logic [MAX_WORDS*32-1:0] payload,
    input  logic [BEAT_W-1:0]       sel,
    output logic [31:0]             word
);
    logic [31:0] words [MAX_WORDS];

    for (genvar g = 0; g < MAX_WORDS; g++) begin : g_unpack
        assign words[g] = payload[g*32 +: 32];
    end

    assign word = words[sel];
endmodule

// File: rtl/wseq_ctrl.sv
module wseq_ctrl
    import wseq_pkg::*;
#(
    parameter int unsigned BYTES_W = 6,
    parameter int unsigned BEAT_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [AD_W-1:0]    req_addr,
    input  logic [BYTES_W-1:0] req_bytes,
    input  logic               req_half_rate,
    input  logic               bus_accept,
    input  logic               bus_retry,
    input  logic               two_part,
    input  logic [BEAT_W-1:0]  last_beat,
    output wseq_state_e        state,
    output logic [AD_W-1:0]    base_addr,
    output logic [BYTES_W-1:0] total_bytes,
    output logic               part,
    output logic [BEAT_W-1:0]  beat,
    output logic               load
);
    typedef struct packed {
        wseq_state_e        st;
        logic [AD_W-1:0]    addr;
        logic [BYTES_W-1:0] bytes;
        logic               slow;
        logic               part;
        logic [BEAT_W-1:0]  beat;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        load   = 1'b0;
        unique case (ctrl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    load        = 1'b1;
                    ctrl_d.st    = ST_ADDR;
                    ctrl_d.addr  = req_addr;
                    ctrl_d.bytes = req_bytes;
                    ctrl_d.slow  = req_half_rate;
                    ctrl_d.part  = 1'b0;
                    ctrl_d.beat  = '0;
                end
            end
            ST_ADDR: begin
                if (bus_accept) begin
                    ctrl_d.st   = ST_DATA;
                    ctrl_d.beat = '0;
                end
            end
            ST_DATA: begin
                if (bus_retry) begin
                    ctrl_d.st   = ST_ADDR;
                    ctrl_d.beat = '0;
                end else if (ctrl_q.beat == last_beat) begin
                    ctrl_d.beat = '0;
                    if (two_part && !ctrl_q.part) begin
                        ctrl_d.st   = ST_ADDR;
                        ctrl_d.part = 1'b1;
                    end else begin
                        ctrl_d.st = ST_IDLE;
                    end
                end else begin
                    ctrl_d.beat = ctrl_q.beat + BEAT_W'(1);
                    ctrl_d.st   = ctrl_q.slow ? ST_GAP : ST_DATA;
                end
            end
            ST_GAP: begin
                if (bus_retry) begin
                    ctrl_d.st   = ST_ADDR;
                    ctrl_d.beat = '0;
                end else begin
                    ctrl_d.st = ST_DATA;
                end
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign state       = ctrl_q.st;
    assign base_addr   = ctrl_q.addr;
    assign total_bytes = ctrl_q.bytes;
    assign part        = ctrl_q.part;
    assign beat        = ctrl_q.beat;

    // R4: the issue cycle is followed at once by data beat 0
    p_issue_to_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.st == ST_ADDR && bus_accept) |=> (ctrl_q.st == ST_DATA && ctrl_q.beat == '0));

    // R8: a spacing cycle always leads into a data cycle unless retried
    p_gap_then_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.st == ST_GAP && !bus_retry) |=> (ctrl_q.st == ST_DATA));

    // R9: a retry returns to the address cycle of the same transaction
    p_retry_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_q.st == ST_DATA || ctrl_q.st == ST_GAP) && bus_retry)
        |=> (ctrl_q.st == ST_ADDR && $stable(ctrl_q.part) && ctrl_q.beat == '0));

    // R10: a held request is not disturbed by new requests while busy
    p_hold_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.st != ST_IDLE) |=> ($stable(ctrl_q.addr) && $stable(ctrl_q.bytes) && $stable(ctrl_q.slow)));

    // R6: the first half of a split write moves on to the second half
    p_split_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.st == ST_DATA && two_part && !ctrl_q.part && ctrl_q.beat == last_beat && !bus_retry)
        |=> (ctrl_q.st == ST_ADDR && ctrl_q.part));
endmodule

// File: rtl/wseq_bus_writer.sv
module wseq_bus_writer
    import wseq_pkg::*;
#(
    parameter int unsigned MAX_WORDS = 8,
    localparam int unsigned BYTES_W  = $clog2(MAX_WORDS*4 + 1),
    localparam int unsigned BEAT_W   = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
    localparam int unsigned PAY_W    = MAX_WORDS * 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [31:0]        req_addr,
    input  logic [BYTES_W-1:0] req_bytes,
    input  logic [PAY_W-1:0]   req_data,
    input  logic               req_half_rate,
    output logic               busy,
    output logic [31:0]        bus_ad,
    output logic [4:0]         bus_cmd,
    output logic               bus_valid,
    input  logic               bus_accept,
    input  logic               bus_retry
);
    wseq_state_e        state;
    logic [AD_W-1:0]    base_addr;
    logic [BYTES_W-1:0] total_bytes;
    logic               part;
    logic [BEAT_W-1:0]  beat;
    logic               load;
    logic               two_part;
    logic               is_block;
    logic [BEAT_W-1:0]  last_beat;
    logic [IDX_W-1:0]   size_code;
    logic [BEAT_W-1:0]  word_sel;
    logic [31:0]        word;
    logic [PAY_W-1:0]   pay_d, pay_q;

    wseq_ctrl #(.BYTES_W(BYTES_W), .BEAT_W(BEAT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_bytes    (req_bytes),
        .req_half_rate(req_half_rate),
        .bus_accept   (bus_accept),
        .bus_retry    (bus_retry),
        .two_part     (two_part),
        .last_beat    (last_beat),
        .state        (state),
        .base_addr    (base_addr),
        .total_bytes  (total_bytes),
        .part         (part),
        .beat         (beat),
        .load         (load)
    );

    wseq_split #(.BYTES_W(BYTES_W), .BEAT_W(BEAT_W)) u_split (
        .total_bytes(total_bytes),
        .part       (part),
        .two_part   (two_part),
        .is_block   (is_block),
        .last_beat  (last_beat),
        .size_code  (size_code)
    );

    assign word_sel = beat + {{(BEAT_W-1){1'b0}}, part};

    wseq_wordsel #(.MAX_WORDS(MAX_WORDS), .BEAT_W(BEAT_W)) u_wordsel (
        .payload(pay_q),
        .sel    (word_sel),
        .word   (word)
    );

    always_comb begin
        pay_d = load ? req_data : pay_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pay_q <= '0;
        end else begin
            pay_q <= pay_d;
        end
    end

    always_comb begin
        bus_valid = 1'b0;
        bus_cmd   = '0;
        bus_ad    = '0;
        unique case (state)
            ST_ADDR: begin
                bus_valid = 1'b1;
                bus_cmd   = {1'b0, is_block, size_code};
                bus_ad    = base_addr + (part ? 32'd4 : 32'd0);
            end
            ST_DATA: begin
                bus_valid = 1'b1;
                bus_cmd   = {1'b1, (beat == last_beat), IDX_W'(beat)};
                bus_ad    = word;
            end
            default: ;
        endcase
    end

    assign busy = (state != ST_IDLE);

    // R11: nothing is strobed while the sequencer is idle
    p_quiet_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_valid);

    // R2: an unaccepted address cycle repeats unchanged
    p_addr_repeat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_cmd[4] && !bus_accept)
        |=> (bus_valid && !bus_cmd[4] && $stable(bus_ad) && $stable(bus_cmd)));

    // R7: a tagged last cycle of an unsplit write ends the request
    p_last_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_cmd[4] && bus_cmd[3] && !bus_retry && !two_part) |=> !busy);
endmodule

// File: tb/wseq_bus_writer_tb.sv
module wseq_bus_writer_tb_top;
    localparam int MW = 8;
    localparam int BW = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [31:0]     req_addr = '0;
    logic [BW-1:0]   req_bytes = '0;
    logic [MW*32-1:0] req_data = '0;
    logic            req_half_rate = 1'b0;
    logic            busy;
    logic [31:0]     bus_ad;
    logic [4:0]      bus_cmd;
    logic            bus_valid;
    logic            bus_accept = 1'b0;
    logic            bus_retry = 1'b0;

    always #10 clk = ~clk;

    wseq_bus_writer #(.MAX_WORDS(MW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_bytes(req_bytes), .req_data(req_data), .req_half_rate(req_half_rate),
        .busy(busy), .bus_ad(bus_ad), .bus_cmd(bus_cmd), .bus_valid(bus_valid),
        .bus_accept(bus_accept), .bus_retry(bus_retry)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference model: 0 idle, 1 address, 2 data, 3 spacing
    int          m_mode = 0;
    logic [31:0] m_addr = '0;
    int          m_bytes = 0;
    bit          m_slow = 0;
    int          m_part = 0;
    int          m_beat = 0;
    logic [31:0] m_w [MW];

    int acc_wait = 0, acc_cnt = 0;
    bit acc_noise = 0;
    bit retry_arm = 0;
    int retry_beat = 0, retry_part = 0;
    int n_last = 0, n_gap = 0, n_issue = 0;

    function automatic int f_nparts(int b);
        return (b >= 5 && b <= 7) ? 2 : 1;
    endfunction
    function automatic int f_nbeats(int b);
        return (b >= 8) ? (b + 3) / 4 : 1;
    endfunction
    function automatic int f_pbytes(int b, int p);
        if (f_nparts(b) == 2) return (p == 0) ? 4 : b - 4;
        return b;
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0;
        end else begin
            case (m_mode)
                0: if (req_valid) begin
                    m_addr  = req_addr;
                    m_bytes = int'(req_bytes);
                    m_slow  = req_half_rate;
                    for (int i = 0; i < MW; i++) m_w[i] = req_data[i*32 +: 32];
                    m_part = 0; m_beat = 0; m_mode = 1;
                end
                1: if (bus_accept) begin m_mode = 2; m_beat = 0; end
                2: begin
                    if (bus_retry) begin
                        m_mode = 1; m_beat = 0;
                    end else if (m_beat == f_nbeats(m_bytes) - 1) begin
                        m_beat = 0;
                        if (f_nparts(m_bytes) == 2 && m_part == 0) begin
                            m_part = 1; m_mode = 1;
                        end else begin
                            m_mode = 0;
                        end
                    end else begin
                        m_beat = m_beat + 1;
                        m_mode = m_slow ? 3 : 2;
                    end
                end
                default: begin
                    if (bus_retry) begin m_mode = 1; m_beat = 0; end
                    else m_mode = 2;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic        ev, eb;
            logic [4:0]  ec;
            logic [31:0] ea;
            int          code;
            string       tag;
            ev = 0; eb = 1; ec = '0; ea = '0; tag = "R8";
            case (m_mode)
                0: begin eb = 0; tag = "R10 R11"; end
                1: begin
                    ev = 1; tag = "R2";
                    code = (m_bytes >= 8) ? f_nbeats(m_bytes) - 1 : f_pbytes(m_bytes, m_part) - 1;
                    ec = {1'b0, (m_bytes >= 8), 3'(code)};
                    ea = m_addr + 32'(4 * m_part);
                end
                2: begin
                    ev = 1; tag = "R3";
                    ec = {1'b1, (m_beat == f_nbeats(m_bytes) - 1), 3'(m_beat)};
                    ea = m_w[m_part + m_beat];
                    if (m_beat == f_nbeats(m_bytes) - 1) n_last++;
                end
                default: n_gap++;
            endcase
            check({bus_valid, busy, bus_cmd, bus_ad} === {ev, eb, ec, ea}, tag,
                  64'({bus_valid, busy, bus_cmd, bus_ad}), 64'({ev, eb, ec, ea}));
            // drive agent for the coming edge
            if (m_mode == 1) begin
                bus_accept = (acc_cnt >= acc_wait);
                if (bus_accept) n_issue++;
                acc_cnt++;
            end else begin
                acc_cnt = 0;
                bus_accept = acc_noise;
            end
            bus_retry = retry_arm && (m_mode == 2 || m_mode == 3)
                        && m_beat == retry_beat && m_part == retry_part;
            if (bus_retry) retry_arm = 0;
        end
    end

    task automatic run_write(int tnum, logic [31:0] a, int b, bit slow, int wt, bit noise,
                             bit rty, int rbeat, int rpart, bit poke);
        acc_wait = wt; acc_noise = noise;
        retry_arm = rty; retry_beat = rbeat; retry_part = rpart;
        n_last = 0; n_gap = 0; n_issue = 0;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_bytes = BW'(b); req_half_rate = slow;
        for (int i = 0; i < MW; i++) req_data[i*32 +: 32] = 32'hD000_0000 | (tnum << 8) | i;
        @(negedge clk);
        req_valid = 0; req_data = '1; req_addr = 32'hFFFF_FFFC;
        if (poke) begin
            repeat (2) @(negedge clk);
            req_valid = 1; req_bytes = BW'(3); req_half_rate = ~slow;
            @(negedge clk);
            req_valid = 0;
        end
        while (m_mode != 0) @(negedge clk);
        check(busy == 1'b0, "R10", 64'(busy), 64'(0));
        if (!rty) begin
            if (b <= 4)
                check(n_last == 1, "R5", 64'(n_last), 64'(1));
            else if (b <= 7)
                check(n_issue == 2 && n_last == 2, "R6", 64'(n_issue*16 + n_last), 64'(34));
            else
                check(n_last == 1, "R7", 64'(n_last), 64'(1));
            check(n_gap == (slow ? f_nparts(b) * (f_nbeats(b) - 1) : 0), "R8",
                  64'(n_gap), 64'(slow ? f_nparts(b) * (f_nbeats(b) - 1) : 0));
            check(n_issue == f_nparts(b), "R4", 64'(n_issue), 64'(f_nparts(b)));
        end else begin
            check(n_issue == f_nparts(b) + 1, "R9", 64'(n_issue), 64'(f_nparts(b) + 1));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check({busy, bus_valid, bus_cmd, bus_ad} == '0, "R1",
              64'({busy, bus_valid, bus_cmd, bus_ad}), 64'(0));
        rst_n = 1;
        @(negedge clk);
        check({busy, bus_valid} == 2'b00, "R1", 64'({busy, bus_valid}), 64'(0));
        // single transfers, R5 and R2 repeats
        run_write(1, 32'h0000_1000, 4, 0, 0, 0, 0, 0, 0, 0);
        run_write(2, 32'h0000_2001, 1, 0, 3, 0, 0, 0, 0, 0);
        run_write(3, 32'h0000_3002, 2, 1, 1, 1, 0, 0, 0, 0);
        run_write(4, 32'h0000_4000, 3, 1, 0, 0, 0, 0, 0, 0);
        // split transfers, R6
        run_write(5, 32'h0000_5000, 5, 0, 0, 0, 0, 0, 0, 0);
        run_write(6, 32'h0000_6000, 6, 0, 2, 1, 0, 0, 0, 0);
        run_write(7, 32'h0000_7000, 7, 1, 1, 0, 0, 0, 0, 0);
        // block transfers, R7 and R8
        run_write(8, 32'h0000_8000, 8, 0, 0, 0, 0, 0, 0, 0);
        run_write(9, 32'h0000_9000, 12, 1, 2, 0, 0, 0, 0, 0);
        run_write(10, 32'h0000_A000, 32, 0, 0, 1, 0, 0, 0, 0);
        run_write(11, 32'h0000_B000, 30, 1, 4, 1, 0, 0, 0, 0);
        // retries, R9
        run_write(12, 32'h0000_C000, 16, 0, 1, 0, 1, 2, 0, 0);
        run_write(13, 32'h0000_D000, 6, 0, 0, 0, 1, 0, 1, 0);
        run_write(14, 32'h0000_E000, 12, 1, 0, 0, 1, 1, 0, 0);
        run_write(15, 32'h0000_F000, 32, 1, 1, 0, 1, 7, 0, 0);
        // request while busy, R10
        run_write(16, 32'h0001_0000, 32, 1, 2, 0, 0, 0, 0, 1);
        run_write(17, 32'h0001_1000, 20, 0, 0, 0, 0, 0, 0, 1);
        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R10 watchdog: actual=busy expected=idle");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule